// File: doc/BRIEF.md
# Serial ADC Power-Mode Tracker

This block sits on the converter side of a three-wire serial link and follows the power state of a 16-clock serial ADC. The only things it sees are the active-low chip select and the serial clock. The host controls the converter's power state purely through framing, with no command register. The block samples both lines through two-flop synchronisers into a faster system clock. It counts serial-clock falling edges in each frame and works out where in the frame chip select was released. From that it keeps track of the mode: normal, partial power-down or full power-down.

Leaving full power-down takes a settling time that is longer than one frame. A parameterised timer in system-clock cycles models that delay. The block reports whether the converter is fully powered. It also raises a one-cycle strobe when a frame completes with data that can be trusted. Data is trusted only if the converter was in normal mode and fully powered when that frame began. Frames used only to wake the converter, frames cut short, and frames started before settling ends never raise the strobe.

The mode on power application is unknown. After reset the block therefore assumes the most pessimistic state, full power-down, and the host must wake the converter with a dummy frame.

Top module: `adc_pwr_mode_tracker`

## Requirements
- R1: After reset, `mode_o` reads full power-down and both `powered_o` and `data_valid_o` are low. The mode codes are 0 for normal, 1 for partial power-down and 2 for full power-down; code 3 never appears.
- R2: A frame starts when chip select falls. Serial-clock falling edges are counted only while chip select is low. If chip select rises after fewer than 2 falling edges, the mode is left unchanged.
- R3: If chip select rises after at least 2 and at most 9 falling edges (the abort window) while the mode is normal, the mode becomes partial power-down.
- R4: An abort-window release in partial power-down moves the mode to full power-down. An abort-window release in full power-down leaves the mode at full power-down. Normal never moves straight to full power-down in one step.
- R5: If the 10th falling edge of a frame arrives in partial power-down, the mode becomes normal and `powered_o` rises within 8 system cycles.
- R6: If the 10th falling edge of a frame arrives in full power-down, the mode becomes normal. `powered_o` then stays low until `PWRUP_CYCLES` system cycles have passed.
- R7: `data_valid_o` pulses high for exactly one cycle on the 16th falling edge of a frame. It pulses only if, when that frame started, the mode was normal and `powered_o` was high. A wake-up frame never pulses, and neither does a frame started before the power-up time has elapsed.
- R8: In normal mode, releasing chip select at or after the 10th falling edge leaves the mode unchanged.
- R9: An abort-window release while the power-up timer is still running moves the mode to partial power-down and cancels the timer. A later wake from partial power-down then powers up at once.
- R10: `powered_o` is high only while the mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for sampling and timing |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Active-low chip select from the host, asynchronous |
| sclk_in | input | 1 | Serial clock from the host, idles high, asynchronous |
| mode_o | output | 2 | Current power mode (0 normal, 1 partial, 2 full) |
| powered_o | output | 1 | Converter in normal mode and past its power-up time |
| data_valid_o | output | 1 | One-cycle strobe: the frame just completed carries valid data |

## Verification
The assertions assume the serial lines are slow compared with the system clock. Each serial-clock phase, and each gap between a chip-select edge and the nearest serial-clock edge, must last several system cycles. Under that condition the synchronised edges of the two lines never land in the same cycle, and a frame cannot reach its 16th edge twice in consecutive cycles.

The stimulus holds every serial-clock half period and every chip-select setup and hold to four system cycles. Random frames vary the edge count, including counts past 16, and vary the gap between frames.

After any wake from full power-down, the gap before the next frame is made either clearly shorter or clearly longer than the power-up time. This keeps the expected validity free of boundary ambiguity.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_PARTIAL = 2'd1,
    PM_FULL    = 2'd2
  } pm_mode_e;

  // one-cycle events produced by the frame counter
  typedef struct packed {
    logic start;    // chip select fell
    logic tenth;    // wake threshold edge reached
    logic last;     // final edge of a full frame reached
    logic abort;    // chip select released inside the abort window
  } frame_evt_t;

endpackage

// File: rtl/adc_pm_sync.sv
module adc_pm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/adc_pm_frame_counter.sv
module adc_pm_frame_counter
  import adc_pm_pkg::*;
#(
  parameter int FRAME_CLKS = 16,
  parameter int ABORT_LO   = 2,
  parameter int WAKE_EDGE  = 10,
  localparam int CW        = $clog2(FRAME_CLKS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_s,
  input  logic       sclk_s,
  output frame_evt_t evt
);

  logic          cs_q, sclk_q;
  logic [CW-1:0] edge_cnt;
  logic          cs_fall, cs_rise, sclk_fall;
  logic          in_window;

  assign cs_fall   = cs_q & ~cs_n_s;
  assign cs_rise   = ~cs_q & cs_n_s;
  assign sclk_fall = sclk_q & ~sclk_s & ~cs_n_s;
  assign in_window = (edge_cnt >= CW'(ABORT_LO)) && (edge_cnt < CW'(WAKE_EDGE));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      edge_cnt <= '0;
      evt      <= '0;
    end else begin
      cs_q   <= cs_n_s;
      sclk_q <= sclk_s;
      evt    <= '0;
      if (cs_fall) begin
        edge_cnt  <= '0;
        evt.start <= 1'b1;
      end else if (sclk_fall && edge_cnt < CW'(FRAME_CLKS)) begin
        edge_cnt  <= edge_cnt + 1'b1;
        evt.tenth <= (edge_cnt == CW'(WAKE_EDGE - 1));
        evt.last  <= (edge_cnt == CW'(FRAME_CLKS - 1));
      end
      if (cs_rise) evt.abort <= in_window;
    end
  end

endmodule

// File: rtl/adc_pm_timer.sv
module adc_pm_timer #(
  parameter int PWRUP_CYCLES = 300,
  localparam int TW          = $clog2(PWRUP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic cancel,
  output logic done
);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (cancel)        remain <= '0;
    else if (load)          remain <= TW'(PWRUP_CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign done = (remain == '0);

endmodule

// File: rtl/adc_pm_mode_ctrl.sv
module adc_pm_mode_ctrl
  import adc_pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  frame_evt_t evt,
  input  logic       tmr_done,
  output logic       tmr_load,
  output logic       tmr_cancel,
  output pm_mode_e   mode,
  output logic       powered,
  output logic       data_valid
);

  pm_mode_e mode_nxt;
  logic     start_ok;

  always_comb begin
    mode_nxt   = mode;
    tmr_load   = 1'b0;
    tmr_cancel = 1'b0;
    if (evt.abort) begin
      unique case (mode)
        PM_NORMAL: begin
          mode_nxt   = PM_PARTIAL;
          tmr_cancel = 1'b1;
        end
        PM_PARTIAL: mode_nxt = PM_FULL;
        default:    mode_nxt = PM_FULL;
      endcase
    end else if (evt.tenth) begin
      if (mode == PM_FULL) begin
        mode_nxt = PM_NORMAL;
        tmr_load = 1'b1;
      end else if (mode == PM_PARTIAL) begin
        mode_nxt = PM_NORMAL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= PM_FULL;
      powered    <= 1'b0;
      data_valid <= 1'b0;
      start_ok   <= 1'b0;
    end else begin
      mode       <= mode_nxt;
      powered    <= (mode_nxt == PM_NORMAL) && tmr_done && !tmr_load;
      data_valid <= evt.last && start_ok;
      if (evt.start) start_ok <= powered;
    end
  end

endmodule

// File: rtl/adc_pwr_mode_tracker.sv
module adc_pwr_mode_tracker
  import adc_pm_pkg::*;
#(
  parameter int FRAME_CLKS   = 16,
  parameter int ABORT_LO     = 2,
  parameter int WAKE_EDGE    = 10,
  parameter int PWRUP_CYCLES = 300,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_in,
  input  logic       sclk_in,
  output logic [1:0] mode_o,
  output logic       powered_o,
  output logic       data_valid_o
);

  logic [1:0] line_s;
  frame_evt_t evt;
  logic       tmr_load, tmr_cancel, tmr_done;
  pm_mode_e   mode;

  adc_pm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_in, cs_n_in}),
    .q   (line_s)
  );

  adc_pm_frame_counter #(
    .FRAME_CLKS (FRAME_CLKS),
    .ABORT_LO   (ABORT_LO),
    .WAKE_EDGE  (WAKE_EDGE)
  ) u_frame (
    .clk    (clk),
    .rst    (rst),
    .cs_n_s (line_s[0]),
    .sclk_s (line_s[1]),
    .evt    (evt)
  );

  adc_pm_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .cancel (tmr_cancel),
    .done   (tmr_done)
  );

  adc_pm_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_cancel (tmr_cancel),
    .mode       (mode),
    .powered    (powered_o),
    .data_valid (data_valid_o)
  );

  assign mode_o = mode;

endmodule

// File: rtl/adc_pm_checker.sv
module adc_pm_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_o,
  input logic       powered_o,
  input logic       data_valid_o
);

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);

  a_r4_no_direct_full: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 2'd0 && mode_o != 2'd0) |-> mode_o == 2'd1);

  a_r4_full_not_partial: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 2'd2) |-> mode_o != 2'd1);

  a_r10_powered_normal: assert property (@(posedge clk) disable iff (rst)
    powered_o |-> mode_o == 2'd0);

  a_r7_valid_powered: assert property (@(posedge clk) disable iff (rst)
    data_valid_o |-> (powered_o && mode_o == 2'd0));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    data_valid_o |=> !data_valid_o);

endmodule

bind adc_pwr_mode_tracker adc_pm_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_o       (mode_o),
  .powered_o    (powered_o),
  .data_valid_o (data_valid_o)
);

// File: tb/adc_pwr_mode_tracker_test.sv
module adc_pwr_mode_tracker_test;

  localparam int PWRUP = 300;
  localparam int HALF  = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b1;
  logic [1:0] mode_o;
  logic powered_o, data_valid_o;

  int errors = 0, checks = 0, vcount = 0;
  int m_mode = 2;      // bench model: 0 normal, 1 partial, 2 full
  bit m_pw   = 1'b0;   // bench model: powered

  always #10 clk = ~clk;

  adc_pwr_mode_tracker #(.PWRUP_CYCLES(PWRUP)) uut (
    .clk(clk), .rst(rst), .cs_n_in(cs_n), .sclk_in(sclk),
    .mode_o(mode_o), .powered_o(powered_o), .data_valid_o(data_valid_o)
  );

  always @(posedge clk) if (data_valid_o) vcount <= vcount + 1;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_mode(int cur, int n);
    if (n < 2) return cur;
    if (n < 10) return (cur == 0) ? 1 : 2;
    return 0;
  endfunction

  function automatic int model_valid(int cur, bit pw, int n);
    return (cur == 0 && pw && n >= 16) ? 1 : 0;
  endfunction

  // drive one frame with n serial-clock falling edges, then update the model
  task automatic frame(int n, output int exp_valid);
    int prev;
    prev = m_mode;
    exp_valid = model_valid(m_mode, m_pw, n);
    @(negedge clk) vcount = 0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    m_mode = model_mode(m_mode, n);
    if (m_mode != 0)                     m_pw = 1'b0;
    else if (n >= 10 && prev == 1)       m_pw = 1'b1;
    else if (n >= 10 && prev == 2)       m_pw = 1'b0;
  endtask

  task automatic run_check(int n, string req);
    int ev;
    frame(n, ev);
    chk(mode_o == 2'(m_mode), req, mode_o, m_mode);
    chk(vcount == ev, req, vcount, ev);
  endtask

  task automatic long_gap();
    repeat (PWRUP + 100) @(negedge clk);
    if (m_mode == 0) m_pw = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(mode_o == 2'd2, "R1 mode", mode_o, 2);
    chk(powered_o == 1'b0, "R1 powered", powered_o, 0);
    chk(data_valid_o == 1'b0, "R1 valid", data_valid_o, 0);

    // R6 wake from full: normal but not powered, wake frame invalid
    run_check(16, "R6 wake");
    chk(powered_o == 1'b0, "R6 powered early", powered_o, 0);
    // R7 frame started before timer expiry is invalid
    run_check(16, "R7 early frame");
    long_gap();
    chk(powered_o == 1'b1, "R6 powered late", powered_o, 1);
    run_check(16, "R7 valid frame");
    // R8 release after 10th edge in normal
    run_check(12, "R8 late release");
    run_check(10, "R8 tenth release");
    // R2 short frames
    run_check(1, "R2 one edge");
    run_check(0, "R2 no edge");
    // R3 lower boundary of abort window
    run_check(2, "R3 abort at 2");
    chk(powered_o == 1'b0, "R3 powered", powered_o, 0);
    // R4 upper boundary, then stay in full
    run_check(9, "R4 abort at 9");
    run_check(5, "R4 full stays");
    // R9 abort during power-up timer
    run_check(10, "R6 wake again");
    run_check(3, "R9 abort in timer");
    chk(powered_o == 1'b0, "R9 powered", powered_o, 0);
    run_check(10, "R5 wake partial");
    chk(powered_o == 1'b1, "R5 powered", powered_o, 1);
    run_check(16, "R7 after partial wake");

    // random phase
    for (int k = 0; k < 60; k++) begin
      int n, r;
      r = $urandom_range(0, 9);
      n = (r < 3) ? 16 : $urandom_range(0, 20);
      run_check(n, "R3 R4 R7 random");
      chk(powered_o == m_pw, "R10 random powered", powered_o, m_pw);
      if ((m_mode == 0 && !m_pw) || $urandom_range(0, 3) == 0) long_gap();
      else repeat ($urandom_range(2, 20)) @(negedge clk);
    end

    summary();
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd1234);
  end

endmodule